// File: doc/BRIEF.md
# Single-Slope Converter Sequencer

This block is the digital core of a single-slope analog-to-digital converter. A free-running ramp counter supplies the code for an external binary-weighted ramp DAC: count zero is the top of the ramp, and each step down the ramp is one more count. The counter stops at its top value until a conversion restart arrives. External comparators return two flags, which the block samples on every clock. One flag says the ramp is still above the analog input. The other says the input is below the under-range floor. From these flags the block drives a pulse-width output. The pulse stays high while the converter is enabled, the input is in range and the ramp is still above the input. The pulse width in clocks therefore encodes the input level.

A conversion is started by holding the restart input high on a clock edge while the enable input is high. When enable is low the pulse output is forced low and a restart request has no effect. For checking, the block also measures each pulse. On the first cycle after a pulse ends, it raises a one-cycle done strobe and presents the pulse length in clocks on a capture output. The capture output holds that value until the next pulse ends.

The pulse tracker is a three-state machine. ST_IDLE means the output is low and no pulse has just ended. ST_PULSE means the output is high. ST_REPORT is the single cycle after a pulse ends, with the output low and the strobe high. The transitions are named as follows. Start: ST_IDLE to ST_PULSE when the gated condition is true. Hold: ST_PULSE stays in ST_PULSE while the condition stays true. End: ST_PULSE to ST_REPORT when the condition drops. Restart: ST_REPORT to ST_PULSE when the condition is true again. Settle: ST_REPORT to ST_IDLE otherwise. Idle: ST_IDLE stays in ST_IDLE while the condition is false.

Top module: `ssadc_ctrl`

## Requirements
- R1: On every rising clock edge where no restart takes effect and the count is below 127, the 7-bit ramp code on `dac_code_o` increases by exactly one. This happens whatever the enable level.
- R2: Once the ramp code reaches 127 it stays at 127 until a restart takes effect. It never wraps to zero.
- R3: When `conv_rst_i` and `enable_i` are both high on a rising edge, the ramp code becomes 0 on that edge. While both stay high it remains 0. Counting resumes on the first edge where the restart is no longer honoured.
- R4: When `enable_i` is low, `conv_rst_i` is ignored and the ramp code keeps advancing as in R1 and R2.
- R5: If `enable_i` is low on a rising edge, `pwm_o` is low after that edge, whatever the comparator flags are.
- R6: If `enable_i` is high and `under_i` is high on a rising edge, `pwm_o` is low after that edge.
- R7: If on a rising edge `enable_i` is high, `under_i` is low and `ramp_gt_i` is high, then `pwm_o` is high after that edge. If `ramp_gt_i` is low (input above the ramp), `pwm_o` is low after that edge.
- R8: `done_o` is high for exactly one cycle: the first cycle in which `pwm_o` is low after having been high. It is low at all other times.
- R9: When `done_o` rises, `width_o` shows the number of consecutive cycles that `pwm_o` was high, saturating at 127. `width_o` keeps that value until the next `done_o`.
- R10: While `rst_n` is low, the ramp code, `pwm_o`, `done_o` and `width_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| enable_i | input | 1 | Converter enable; gates the output and the restart |
| conv_rst_i | input | 1 | Conversion restart, sampled on the clock edge |
| under_i | input | 1 | Comparator flag: input below the under-range floor |
| ramp_gt_i | input | 1 | Comparator flag: ramp above the input |
| dac_code_o | output | 7 | Ramp DAC code (0 = top of ramp) |
| pwm_o | output | 1 | Pulse-width encoded result |
| done_o | output | 1 | One-cycle strobe after a pulse ends |
| width_o | output | 7 | Length in clocks of the last completed pulse |

## Verification
Two situations are hard to reach from the ports.

The first is the width saturation case. A pulse must outlast 127 clocks, so the ramp comparator must stay true past the point where the counter has pinned at its top value. The stimulus starts a conversion with an input threshold above the ramp range, lets the counter run into its hold for more than 130 cycles, and only then drops the comparator flag.

The second is the restart from ST_REPORT straight back into ST_PULSE. The comparator flag must toggle high-low-high on successive edges, with no idle cycle between two pulses. The bench overrides the ramp-derived flag and drives that pattern directly, so a done strobe and a new one-cycle pulse follow each other back to back.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;

    // Pulse tracker states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PULSE  = 2'd1,
        ST_REPORT = 2'd2
    } pulse_st_e;

    // Gated pulse condition shared by the tracker
    function automatic logic pulse_cond(input logic en, input logic under, input logic gt);
        return en & ~under & gt;
    endfunction

endpackage

// File: rtl/ssadc_ramp_counter.sv
module ssadc_ramp_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             conv_rst_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;
    logic             restart;
    logic             at_top;

    // A restart request only counts while the converter is enabled
    assign restart = enable_i & conv_rst_i;
    assign at_top  = (count_q == CNT_TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (restart) begin
            count_q <= '0;
        end else if (!at_top) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/ssadc_pulse_fsm.sv
module ssadc_pulse_fsm
    import ssadc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic under_i,
    input  logic ramp_gt_i,
    output logic pwm_o,
    output logic done_o,
    output logic start_o,
    output logic hold_o,
    output logic end_o
);

    pulse_st_e state_q, state_d;
    logic      cond;

    assign cond = pulse_cond(enable_i, under_i, ramp_gt_i);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = cond ? ST_PULSE : ST_IDLE;
            ST_PULSE:  state_d = cond ? ST_PULSE : ST_REPORT;
            ST_REPORT: state_d = cond ? ST_PULSE : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        pwm_o   = 1'b0;
        done_o  = 1'b0;
        start_o = 1'b0;
        hold_o  = 1'b0;
        end_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                start_o = cond;
            end
            ST_PULSE: begin
                pwm_o  = 1'b1;
                hold_o = cond;
                end_o  = ~cond;
            end
            ST_REPORT: begin
                done_o  = 1'b1;
                start_o = cond;
            end
            default: begin
                pwm_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ssadc_width_capture.sv
module ssadc_width_capture #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             hold_i,
    input  logic             end_i,
    output logic [CNT_W-1:0] width_o
);

    localparam logic [CNT_W-1:0] WID_TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] WID_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] cap_q;

    // Running length of the current pulse, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (start_i) begin
            run_q <= WID_ONE;
        end else if (hold_i && (run_q != WID_TOP)) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Latched length of the last finished pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (end_i) begin
            cap_q <= run_q;
        end
    end

    assign width_o = cap_q;

endmodule

// File: rtl/ssadc_ctrl.sv
module ssadc_ctrl #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             conv_rst_i,
    input  logic             under_i,
    input  logic             ramp_gt_i,
    output logic [CNT_W-1:0] dac_code_o,
    output logic             pwm_o,
    output logic             done_o,
    output logic [CNT_W-1:0] width_o
);

    logic pulse_start;
    logic pulse_hold;
    logic pulse_end;

    ssadc_ramp_counter #(.CNT_W(CNT_W)) ramp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .conv_rst_i (conv_rst_i),
        .count_o    (dac_code_o)
    );

    ssadc_pulse_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable_i),
        .under_i   (under_i),
        .ramp_gt_i (ramp_gt_i),
        .pwm_o     (pwm_o),
        .done_o    (done_o),
        .start_o   (pulse_start),
        .hold_o    (pulse_hold),
        .end_o     (pulse_end)
    );

    ssadc_width_capture #(.CNT_W(CNT_W)) cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (pulse_start),
        .hold_i  (pulse_hold),
        .end_i   (pulse_end),
        .width_o (width_o)
    );

endmodule

// File: rtl/ssadc_ctrl_chk.sv
module ssadc_ctrl_chk #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable_i,
    input logic             conv_rst_i,
    input logic             under_i,
    input logic [CNT_W-1:0] dac_code_o,
    input logic             pwm_o,
    input logic             done_o,
    input logic [CNT_W-1:0] width_o
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(enable_i && conv_rst_i) && dac_code_o != TOP) |=> dac_code_o == $past(dac_code_o) + 1'b1);

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(enable_i && conv_rst_i) && dac_code_o == TOP) |=> dac_code_o == TOP);

    // R3
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && conv_rst_i) |=> dac_code_o == '0);

    // R5
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !pwm_o);

    // R6
    under_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        under_i |=> !pwm_o);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!pwm_o && $past(pwm_o)));

    // R9
    width_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(width_o));

    // R9
    width_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> width_o != '0);

endmodule

bind ssadc_ctrl ssadc_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable_i),
    .conv_rst_i (conv_rst_i),
    .under_i    (under_i),
    .dac_code_o (dac_code_o),
    .pwm_o      (pwm_o),
    .done_o     (done_o),
    .width_o    (width_o)
);

// File: tb/ssadc_ctrl_tb_top.sv
`timescale 1ns/1ps
module ssadc_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b0;
    logic       conv_rst_i = 1'b0;
    logic       under_i = 1'b0;
    logic       ramp_gt_i = 1'b0;
    logic [6:0] dac_code_o;
    logic       pwm_o;
    logic       done_o;
    logic [6:0] width_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference model state
    int m_cnt = 0;
    int m_width = 0;
    int m_cap = 0;
    bit m_pwm = 1'b0;
    bit m_done = 1'b0;

    // Comparator stimulus control
    int thr = 0;
    bit force_en = 1'b0;
    bit force_val = 1'b0;

    always #2.5 clk = ~clk;

    ssadc_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .conv_rst_i (conv_rst_i),
        .under_i    (under_i),
        .ramp_gt_i  (ramp_gt_i),
        .dac_code_o (dac_code_o),
        .pwm_o      (pwm_o),
        .done_o     (done_o),
        .width_o    (width_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string ctx);
        check({ctx, " code R1/R2/R3/R4"}, int'(dac_code_o), m_cnt);
        check({ctx, " pwm R5/R6/R7"}, int'(pwm_o), int'(m_pwm));
        check({ctx, " done R8"}, int'(done_o), int'(m_done));
        check({ctx, " width R9"}, int'(width_o), m_cap);
    endtask

    task automatic model_reset();
        m_cnt = 0; m_width = 0; m_cap = 0; m_pwm = 1'b0; m_done = 1'b0;
    endtask

    task automatic step(input string ctx);
        bit g;
        bit p;
        g = force_en ? force_val : (m_cnt < thr);
        ramp_gt_i = g;
        @(posedge clk);
        if (!rst_n) begin
            model_reset();
        end else begin
            p = enable_i && !under_i && g;
            if (enable_i && conv_rst_i) m_cnt = 0;
            else if (m_cnt < 127) m_cnt++;
            m_done = m_pwm && !p;
            if (m_done) m_cap = m_width;
            if (p) m_width = m_pwm ? ((m_width < 127) ? m_width + 1 : 127) : 1;
            m_pwm = p;
        end
        @(negedge clk);
        compare_all(ctx);
    endtask

    task automatic run(input int n, input string ctx);
        for (int i = 0; i < n; i++) step(ctx);
    endtask

    task automatic start_conv(input int t, input string ctx);
        thr = t;
        enable_i = 1'b1;
        conv_rst_i = 1'b1;
        step({ctx, " restart R3"});
        conv_rst_i = 1'b0;
    endtask

    initial begin
        // Reset state, R10
        @(negedge clk);
        #0.1;
        compare_all("R10 reset");
        run(3, "R10 held reset");
        rst_n = 1'b1;

        // Normal conversions at several levels, R7 R8 R9
        start_conv(20, "lvl20");
        run(30, "R7 lvl20");
        start_conv(5, "lvl5");
        run(10, "R7 lvl5");
        start_conv(0, "lvl0");
        run(10, "R7 lvl0");
        start_conv(60, "lvl60");
        run(70, "R7 lvl60");

        // Under-range flag, R6
        start_conv(50, "under");
        under_i = 1'b1;
        run(10, "R6 under");
        under_i = 1'b0;
        run(50, "R6 release");

        // Enable dropped mid pulse, R5
        start_conv(40, "endrop");
        run(10, "R5 before");
        enable_i = 1'b0;
        run(5, "R5 disabled");
        enable_i = 1'b1;
        run(40, "R5 re-enabled");

        // Restart ignored while disabled, R4
        enable_i = 1'b0;
        conv_rst_i = 1'b1;
        run(6, "R4 restart ignored");
        conv_rst_i = 1'b0;
        enable_i = 1'b1;

        // Restart held with enable, R3
        thr = 0;
        conv_rst_i = 1'b1;
        run(5, "R3 restart held");
        conv_rst_i = 1'b0;
        run(3, "R3 resume");

        // Counter pins at top and width saturates, R2 R9
        start_conv(1000, "sat");
        run(140, "R2 top hold");
        thr = 0;
        run(3, "R9 saturated width");

        // Back-to-back pulses through the report state, R8
        force_en = 1'b1;
        force_val = 1'b1; step("R8 b2b");
        force_val = 1'b0; step("R8 b2b");
        force_val = 1'b1; step("R8 b2b");
        force_val = 1'b1; step("R8 b2b");
        force_val = 1'b0; step("R8 b2b");
        force_val = 1'b1; step("R8 b2b");
        force_val = 1'b0; step("R8 b2b");
        run(3, "R8 b2b tail");
        force_en = 1'b0;

        // Asynchronous reset mid conversion, R10
        start_conv(30, "async");
        run(8, "R7 async pre");
        #1 rst_n = 1'b0;
        #0.1;
        model_reset();
        compare_all("R10 async");
        run(2, "R10 async held");
        rst_n = 1'b1;
        start_conv(12, "post");
        run(20, "R9 post");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule